// File: doc/BRIEF.md
# Addressed PWM Level Converter Bank

This block provides a bank of pulse-width-modulated outputs that act as coarse digital-to-analog converters once filtered outside the chip. Each channel has an 8-bit duty register. The registers sit in the row/column cell space that an on-screen character controller already decodes. A host writes them through a simple strobed port that carries a row, a column and a data byte. Writes that hit no duty cell are dropped. A single free-running 8-bit counter is shared by all channels. The counter advances once every 2^PRESC_W clock cycles. A channel pulls its pin low while the counter is below its active duty value.

Each output is modelled as an open-drain pin. The block gives a level that is always low and an output-enable, so an external pull-up sets the released level. A newly written duty value waits in a pending register. It moves to the active register only when the counter wraps from 255 to 0, so a period is never cut short or stretched. A separate shared pin carries one of two signals, chosen by a select input. One is the prescaler's reference clock. The other is a half-tone strobe that tells the video path to attenuate the external red, green and blue gain for a see-through window.

Top module: `pwm_dac_bank`

## Requirements
- R1: While reset is high and in the first cycle after it, every duty register holds zero and every channel's output-enable is low.
- R2: A strobed write to row 15, column 22+k (k from 0 to NUM_CH-1) sets channel k's pending duty. With NUM_CH=5 these are columns 22 to 26, which are channels 3 to 7 in the pin numbering, in ascending order.
- R3: A write whose row is not 15, or whose column lies outside 22 to 22+NUM_CH-1, changes no channel's duty. A cycle with the strobe low also changes no duty.
- R4: In steady state, within every counter period of 256·2^PRESC_W cycles, channel k's output-enable is high for exactly duty_k·2^PRESC_W cycles.
- R5: Duty 0 keeps a channel released for the whole period. Duty 255 keeps it pulled low for all counter steps except one.
- R6: A pending duty becomes active only on the cycle the counter wraps from 255 to 0. Before that wrap, the output follows the old value.
- R7: The level output of every channel is always 0. A channel only ever pulls low or releases.
- R8: With the select input at 0, the shared pin equals the half-tone input.
- R9: With the select input at 1, the shared pin is the reference clock, which is the prescaler MSB. It is a square wave with a period of 2^PRESC_W cycles, and the half-tone input has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| wr_row_i | input | 5 | Target row of the write |
| wr_col_i | input | 5 | Target column of the write |
| wr_data_i | input | 8 | Duty value written |
| clk_sel_i | input | 1 | Shared-pin select: 0 gives half-tone, 1 gives reference clock |
| halftone_i | input | 1 | Half-tone attenuation strobe from the video path |
| pwm_lvl_o | output | NUM_CH | Level driven when enabled (always 0) |
| pwm_oe_o | output | NUM_CH | Output-enable: 1 pulls the pin low |
| share_o | output | 1 | Shared pin: reference clock or half-tone |

## Verification
The bench builds the block with PRESC_W=1. This makes a full counter period 512 cycles and makes the reference clock toggle on every cycle. Low-time counts over whole periods, the wrap-aligned deferral of a new duty value, and the waveform of the shared pin can then all be checked exactly within a few thousand cycles. The default NUM_CH=5, row 15 and first column 22 are kept. This leaves the column boundaries at 21 and 27 to be probed as ignored writes.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int DUTY_W = 8;
    localparam int ADDR_W = 5;

    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  en;
        addr_t row;
        addr_t col;
        duty_t data;
    } wr_cmd_t;

    typedef enum logic {
        SHARE_HALFTONE = 1'b0,
        SHARE_REFCLK   = 1'b1
    } share_sel_e;

    function automatic logic below_duty(input duty_t cnt, input duty_t duty);
        return cnt < duty;
    endfunction

endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH    = 5,
    parameter int DUTY_ROW  = 15,
    parameter int FIRST_COL = 22
) (
    input  wr_cmd_t           cmd,
    output logic [NUM_CH-1:0] ch_sel,
    output logic              any_hit
);
    localparam addr_t ROW_MATCH = ADDR_W'(DUTY_ROW);

    logic row_ok;
    assign row_ok = cmd.en && (cmd.row == ROW_MATCH);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_col
        localparam addr_t COL_K = ADDR_W'(FIRST_COL + k);
        assign ch_sel[k] = row_ok && (cmd.col == COL_K);
    end

    assign any_hit = |ch_sel;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_bank_pkg::*;
#(
    parameter int PRESC_W = 4
) (
    input  logic  clk,
    input  logic  rst,
    output duty_t cnt,
    output logic  wrap,
    output logic  refclk
);
    logic [PRESC_W-1:0] presc;
    logic               tick;

    assign tick   = &presc;
    assign wrap   = tick && (&cnt);
    assign refclk = presc[PRESC_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            presc <= '0;
            cnt   <= '0;
        end else begin
            presc <= presc + 1'b1;
            if (tick) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_sel,
    input  duty_t wr_data,
    input  logic  wrap,
    input  duty_t cnt,
    output duty_t pend,
    output duty_t act,
    output logic  pull
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            act  <= '0;
        end else begin
            if (wr_sel) pend <= wr_data;
            if (wrap)   act  <= pend;
        end
    end

    assign pull = below_duty(cnt, act);
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH    = 5,
    parameter int DUTY_ROW  = 15,
    parameter int FIRST_COL = 22,
    parameter int PRESC_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [4:0]        wr_row_i,
    input  logic [4:0]        wr_col_i,
    input  logic [7:0]        wr_data_i,
    input  logic              clk_sel_i,
    input  logic              halftone_i,
    output logic [NUM_CH-1:0] pwm_lvl_o,
    output logic [NUM_CH-1:0] pwm_oe_o,
    output logic              share_o
);
    localparam int FLAT_W = NUM_CH * DUTY_W;

    wr_cmd_t           cmd;
    logic [NUM_CH-1:0] ch_sel;
    logic              any_hit;
    duty_t             cnt;
    logic              wrap;
    logic              refclk;
    logic [FLAT_W-1:0] pend_flat;
    logic [FLAT_W-1:0] act_flat;
    share_sel_e        sel;

    assign cmd = '{en: wr_en_i, row: wr_row_i, col: wr_col_i, data: wr_data_i};

    pwm_addr_dec #(
        .NUM_CH(NUM_CH), .DUTY_ROW(DUTY_ROW), .FIRST_COL(FIRST_COL)
    ) u_dec (
        .cmd(cmd), .ch_sel(ch_sel), .any_hit(any_hit)
    );

    pwm_timebase #(.PRESC_W(PRESC_W)) u_tb (
        .clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap), .refclk(refclk)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        pwm_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .wr_sel (ch_sel[k]),
            .wr_data(cmd.data),
            .wrap   (wrap),
            .cnt    (cnt),
            .pend   (pend_flat[k*DUTY_W +: DUTY_W]),
            .act    (act_flat[k*DUTY_W +: DUTY_W]),
            .pull   (pwm_oe_o[k])
        );
        assign pwm_lvl_o[k] = 1'b0;
    end

    assign sel = share_sel_e'(clk_sel_i);

    always_comb begin
        case (sel)
            SHARE_REFCLK: share_o = refclk;
            default:      share_o = halftone_i;
        endcase
    end
endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk #(
    parameter int NUM_CH = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                any_hit,
    input logic                wrap,
    input logic [NUM_CH*8-1:0] pend_flat,
    input logic [NUM_CH*8-1:0] act_flat,
    input logic [NUM_CH-1:0]   oe
);
    assert_reset_release_R1: assert property (@(posedge clk)
        rst |=> (oe == '0));

    assert_miss_no_change_R3: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && any_hit)) |=> $stable(pend_flat));

    assert_hold_until_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act_flat));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_a
        assert_period_start_R5: assert property (@(posedge clk) disable iff (rst)
            wrap |=> (oe[k] == (act_flat[k*8 +: 8] != 8'd0)));
    end
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en_i),
    .any_hit  (any_hit),
    .wrap     (wrap),
    .pend_flat(pend_flat),
    .act_flat (act_flat),
    .oe       (pwm_oe_o)
);

// File: tb/tb_pwm_dac_bank.sv
module tb_pwm_dac_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 5;
    localparam int PW         = 1;
    localparam int PERIOD     = 256 * (1 << PW);
    localparam int NVEC       = 4;
    localparam logic [7:0] VEC [NVEC][NCH] = '{
        '{8'd0,   8'd1,   8'd128, 8'd254, 8'd255},
        '{8'd255, 8'd0,   8'd77,  8'd3,   8'd200},
        '{8'd10,  8'd20,  8'd30,  8'd40,  8'd50},
        '{8'd99,  8'd255, 8'd1,   8'd0,   8'd128}
    };

    logic           clk = 0;
    logic           rst = 1;
    logic           wr_en = 0;
    logic [4:0]     wr_row = 0, wr_col = 0;
    logic [7:0]     wr_data = 0;
    logic           clk_sel = 0, halftone = 0;
    logic [NCH-1:0] lvl, oe;
    logic           share;

    int n_chk = 0, n_bad = 0;
    int lowcnt [NCH];
    int lvl_bad;
    logic [7:0] cur [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dac_bank #(.PRESC_W(PW)) dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_row_i(wr_row), .wr_col_i(wr_col),
        .wr_data_i(wr_data), .clk_sel_i(clk_sel), .halftone_i(halftone),
        .pwm_lvl_o(lvl), .pwm_oe_o(oe), .share_o(share)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int row, input int col, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_row = 5'(row); wr_col = 5'(col); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic measure();
        for (int k = 0; k < NCH; k++) lowcnt[k] = 0;
        lvl_bad = 0;
        for (int t = 0; t < PERIOD; t++) begin
            @(negedge clk);
            for (int k = 0; k < NCH; k++) if (oe[k]) lowcnt[k]++;
            if (lvl != '0) lvl_bad++;
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < NCH; k++)
            check(req, lowcnt[k], int'(cur[k]) * (1 << PW));
        check("R7 level always low", lvl_bad, 0);
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) cur[k] = 8'd0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 oe in reset", int'(oe), 0);
        rst = 0;
        @(negedge clk);
        check("R1 oe after reset", int'(oe), 0);
        measure();
        check_all("R1 zero duty after reset");

        // R2 R4 R5: table of duty sets, column 22+k -> channel k
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < NCH; k++) begin
                wr(15, 22 + k, VEC[v][k]);
                cur[k] = VEC[v][k];
            end
            repeat (PERIOD + 100) @(negedge clk);
            measure();
            check_all("R2/R4/R5 low time");
        end

        // R3: writes to missed cells and unstrobed writes are ignored
        wr(14, 22, 8'hAA);
        wr(15, 21, 8'hAA);
        wr(15, 27, 8'hAA);
        wr(31, 24, 8'hAA);
        @(negedge clk);
        wr_en = 0; wr_row = 5'd15; wr_col = 5'd23; wr_data = 8'hAA;
        repeat (3) @(negedge clk);
        repeat (PERIOD + 100) @(negedge clk);
        measure();
        check_all("R3 ignored writes");

        // R6: deferred update at wrap
        wr(15, 22, 8'd255);
        wr(15, 23, 8'd0);
        cur[0] = 8'd255; cur[1] = 8'd0;
        repeat (PERIOD + 100) @(negedge clk);
        while (oe[0] !== 1'b0) @(negedge clk);
        while (oe[0] !== 1'b1) @(negedge clk);
        repeat (20) @(negedge clk);
        wr(15, 23, 8'd200);
        begin
            int early = 0;
            for (int t = 0; t < 400; t++) begin
                @(negedge clk);
                if (oe[1]) early++;
            end
            check("R6 old duty holds before wrap", early, 0);
        end
        while (oe[0] !== 1'b0) @(negedge clk);
        while (oe[0] !== 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R6 new duty after wrap", int'(oe[1]), 1);

        // R8: half-tone passes through when select is 0
        clk_sel = 0; halftone = 1;
        @(negedge clk);
        check("R8 share follows halftone=1", int'(share), 1);
        halftone = 0;
        @(negedge clk);
        check("R8 share follows halftone=0", int'(share), 0);

        // R9: reference clock when select is 1, half-tone has no effect
        clk_sel = 1;
        begin
            int highs = 0, stuck = 0;
            logic prev;
            @(negedge clk);
            prev = share;
            for (int t = 0; t < PERIOD; t++) begin
                halftone = t[2];
                @(negedge clk);
                if (share) highs++;
                if (share == prev) stuck++;
                prev = share;
            end
            check("R9 refclk high time", highs, PERIOD / 2);
            check("R9 refclk toggles each cycle", stuck, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule